// File: doc/BRIEF.md
# Sticky Interrupt Gatherer with Clear-on-Read

This block collects single-cycle event pulses from a sensor hub into sticky status bits. There are two registers. A bus-master status byte records per-target NACKs, lost arbitration, completion of the on-demand (slave-4) transfer and an external sync edge. A top-level status byte holds a data-ready bit, a FIFO-overflow bit and one summary bit that stands for every bus-master event. From these bits the block drives one interrupt pin. Its polarity is selectable, and so is the pin style: a level latched until the status is read, or a pulse of fixed width.

The host reads either register through a read strobe and an address, and the same read clears the register. A configuration bit widens the clearing to any read strobe at all. An event that lands in the same cycle as a clearing read is kept. The pin-configuration byte also holds an open-drain select, which the block passes straight to the pad.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset both status registers read 0, and the pin sits at its inactive level (0 when pin_cfg_i[7]=0).
- R2: Master status bits are sticky. Bits [NUM_SLV-1:0] are set by nack_evt_i[i], bit 5 by arb_lost_evt_i, bit 6 by s4_done_evt_i and bit 7 by the sync pass-through. Each bit stays set until it is cleared.
- R3: A read strobe at MST_ADDR returns the master byte as it was before the read, and clears every bit of that byte on the following edge.
- R4: In the top-level status byte, bit 0 is data-ready, bit 3 is the bus-master summary and bit 4 is FIFO overflow. Bits 0 and 4 set only while the enable bit at the same position in irq_en_i is 1. Bits 7:5 and 2:1 always read 0, even when the same bits of irq_en_i are set.
- R5: A read strobe at STAT_ADDR returns the top-level byte and clears it.
- R6: The summary bit sets on any bus-master event only while irq_en_i[3]=1. A slave-4 completion counts toward it only when s4_irq_en_i=1 as well. The master byte records the event either way.
- R7: When pin_cfg_i[2]=1, a change of sync_i to its active level sets master bit 7 and counts as a bus-master event. The active level is high when pin_cfg_i[3]=0 and low when it is 1. A change to the inactive level does nothing.
- R8: When pin_cfg_i[4]=1, any read strobe clears both registers, whatever the address.
- R9: An event in the same cycle as a clearing read leaves its bit set after that read.
- R10: In latched mode (pin_cfg_i[5]=1), the pin is active exactly while some top-level status bit is set and its enable bit in irq_en_i is 1.
- R11: In pulse mode (pin_cfg_i[5]=0), each enabled event makes the pin active for PULSE_CLKS = CLK_MHZ*PULSE_US cycles. A new event restarts the count.
- R12: The pin level is inverted when pin_cfg_i[7]=1, and irq_od_o follows pin_cfg_i[6].
- R13: A read at any other address returns 0 and clears nothing unless pin_cfg_i[4]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drdy_evt_i | input | 1 | Data-ready event pulse |
| fifo_ovf_evt_i | input | 1 | FIFO overflow event pulse |
| nack_evt_i | input | NUM_SLV | Per-target NACK event pulses |
| arb_lost_evt_i | input | 1 | Lost-arbitration event pulse |
| s4_done_evt_i | input | 1 | Slave-4 transfer completion pulse |
| sync_i | input | 1 | External sync pin |
| pin_cfg_i | input | 8 | Pin configuration byte |
| irq_en_i | input | 8 | Interrupt enable byte |
| s4_irq_en_i | input | 1 | Slave-4 completion interrupt enable |
| rd_stb_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read address |
| irq_pin_o | output | 1 | Interrupt pin level |
| irq_od_o | output | 1 | Open-drain select for the pad |
| rd_data_o | output | 8 | Read data of the addressed status register |

## Verification
A source event and a read that clears its register can fall in the same cycle. The risk is that the clear drops an event the host has not yet seen. The bench provokes this by raising data-ready or a NACK in the very cycle a status or master read is strobed. It checks that the read returned the old contents and that a second read finds the new bit. A second collision is a fresh event arriving during a running pulse. The bench times one exactly three cycles into the pulse and counts the active cycles against PULSE_CLKS+3.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DATA_W  = 8;
  localparam int SB_DRDY = 0;
  localparam int SB_MST  = 3;
  localparam int SB_FOVF = 4;
  localparam logic [DATA_W-1:0] SB_MASK = 8'h19;

  typedef struct packed {
    logic       act_low;
    logic       open_drain;
    logic       latch;
    logic       any_rd_clr;
    logic       sync_low;
    logic       sync_en;
    logic [1:0] unused;
  } pin_cfg_t;
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic low_i,
  input  logic en_i,
  output logic edge_o
);
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  // transition into the active level only
  assign edge_o = en_i & (low_i ? (sync_q & ~sync_i) : (~sync_q & sync_i));
endmodule

// File: rtl/evt_sticky_reg.sv
module evt_sticky_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (clr_i ? '0 : q_o) | set_i;  // set beats clear
  end
endmodule

// File: rtl/evt_pin_drv.sv
module evt_pin_drv #(
  parameter int PULSE_CLKS = 12500,
  localparam int CNT_W = $clog2(PULSE_CLKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic lat_act_i,
  input  logic latch_i,
  input  logic act_low_i,
  output logic pin_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (trig_i)        cnt_q <= CNT_W'(PULSE_CLKS);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = latch_i ? lat_act_i : (cnt_q != '0);
  assign pin_o  = active ^ act_low_i;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_SLV = 5,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h1A,
  parameter logic [ADDR_W-1:0] MST_ADDR  = 'h19,
  parameter int CLK_MHZ  = 250,
  parameter int PULSE_US = 50
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               drdy_evt_i,
  input  logic               fifo_ovf_evt_i,
  input  logic [NUM_SLV-1:0] nack_evt_i,
  input  logic               arb_lost_evt_i,
  input  logic               s4_done_evt_i,
  input  logic               sync_i,
  input  logic [7:0]         pin_cfg_i,
  input  logic [7:0]         irq_en_i,
  input  logic               s4_irq_en_i,
  input  logic               rd_stb_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic               irq_pin_o,
  output logic               irq_od_o,
  output logic [7:0]         rd_data_o
);
  localparam int MST_W      = NUM_SLV + 3;
  localparam int ARB_BIT    = NUM_SLV;
  localparam int DONE_BIT   = NUM_SLV + 1;
  localparam int PASS_BIT   = NUM_SLV + 2;
  localparam int PULSE_CLKS = CLK_MHZ * PULSE_US;

  pin_cfg_t            cfg;
  logic                sync_hit;
  logic [MST_W-1:0]    mst_set, mst_q;
  logic [DATA_W-1:0]   stat_set, stat_q;
  logic                mst_hit, rd_any, clr_stat, clr_mst;

  assign cfg = pin_cfg_t'(pin_cfg_i);

  evt_sync_edge i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .low_i  (cfg.sync_low),
    .en_i   (cfg.sync_en),
    .edge_o (sync_hit)
  );

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_nack
    assign mst_set[g] = nack_evt_i[g];
  end
  assign mst_set[ARB_BIT]  = arb_lost_evt_i;
  assign mst_set[DONE_BIT] = s4_done_evt_i;
  assign mst_set[PASS_BIT] = sync_hit;

  assign mst_hit = irq_en_i[SB_MST] &
                   (|nack_evt_i | arb_lost_evt_i | (s4_done_evt_i & s4_irq_en_i) | sync_hit);

  always_comb begin
    stat_set          = '0;
    stat_set[SB_DRDY] = drdy_evt_i & irq_en_i[SB_DRDY];
    stat_set[SB_FOVF] = fifo_ovf_evt_i & irq_en_i[SB_FOVF];
    stat_set[SB_MST]  = mst_hit;
  end

  assign rd_any   = rd_stb_i & cfg.any_rd_clr;
  assign clr_stat = (rd_stb_i & (rd_addr_i == STAT_ADDR)) | rd_any;
  assign clr_mst  = (rd_stb_i & (rd_addr_i == MST_ADDR)) | rd_any;

  evt_sticky_reg #(.W(MST_W)) i_mst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mst_set),
    .clr_i  (clr_mst),
    .q_o    (mst_q)
  );

  evt_sticky_reg #(.W(DATA_W)) i_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stat_set),
    .clr_i  (clr_stat),
    .q_o    (stat_q)
  );

  evt_pin_drv #(.PULSE_CLKS(PULSE_CLKS)) i_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (|stat_set),
    .lat_act_i (|(stat_q & irq_en_i & SB_MASK)),
    .latch_i   (cfg.latch),
    .act_low_i (cfg.act_low),
    .pin_o     (irq_pin_o)
  );

  assign irq_od_o = cfg.open_drain;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == STAT_ADDR)     rd_data_o = stat_q;
    else if (rd_addr_i == MST_ADDR) rd_data_o = DATA_W'(mst_q);
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int NUM_SLV = 5,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h1A,
  parameter logic [ADDR_W-1:0] MST_ADDR  = 'h19
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               drdy_evt_i,
  input logic [NUM_SLV-1:0] nack_evt_i,
  input logic               arb_lost_evt_i,
  input logic               s4_done_evt_i,
  input logic [7:0]         pin_cfg_i,
  input logic [7:0]         irq_en_i,
  input logic               rd_stb_i,
  input logic [ADDR_W-1:0]  rd_addr_i,
  input logic               irq_pin_o,
  input logic [7:0]         stat_q,
  input logic [NUM_SLV+2:0] mst_q
);
  a_r4_drdy_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[0]) |-> $past(irq_en_i[0]));

  a_r6_summary_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[3]) |-> $past(irq_en_i[3]));

  a_r9_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drdy_evt_i && irq_en_i[0]) |=> stat_q[0]);

  a_r3_mst_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && rd_addr_i == MST_ADDR && nack_evt_i == '0 && !arb_lost_evt_i &&
     !s4_done_evt_i && !pin_cfg_i[2]) |=> mst_q == '0);

  a_r2_arb_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_q[NUM_SLV] && !(rd_stb_i && (rd_addr_i == MST_ADDR || pin_cfg_i[4])))
    |=> mst_q[NUM_SLV]);

  a_r10_latch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_cfg_i[5] && (stat_q & irq_en_i & 8'h19) == 8'h00) |-> irq_pin_o == pin_cfg_i[7]);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .NUM_SLV(NUM_SLV), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MST_ADDR(MST_ADDR)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .drdy_evt_i     (drdy_evt_i),
  .nack_evt_i     (nack_evt_i),
  .arb_lost_evt_i (arb_lost_evt_i),
  .s4_done_evt_i  (s4_done_evt_i),
  .pin_cfg_i      (pin_cfg_i),
  .irq_en_i       (irq_en_i),
  .rd_stb_i       (rd_stb_i),
  .rd_addr_i      (rd_addr_i),
  .irq_pin_o      (irq_pin_o),
  .stat_q         (stat_q),
  .mst_q          (mst_q)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
  localparam int P = 6;
  localparam logic [7:0] STA = 8'h1A;
  localparam logic [7:0] MST = 8'h19;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       drdy = 1'b0, fovf = 1'b0, arb = 1'b0, dn = 1'b0, sync = 1'b0;
  logic [4:0] nack = '0;
  logic [7:0] pin_cfg = 8'h20, irq_en = 8'h19;
  logic       s4en = 1'b1;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_addr = '0;
  logic       irq_pin, irq_od;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  evt_irq_ctrl #(.CLK_MHZ(2), .PULSE_US(3)) i_evt_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .drdy_evt_i(drdy), .fifo_ovf_evt_i(fovf),
    .nack_evt_i(nack), .arb_lost_evt_i(arb), .s4_done_evt_i(dn), .sync_i(sync),
    .pin_cfg_i(pin_cfg), .irq_en_i(irq_en), .s4_irq_en_i(s4en),
    .rd_stb_i(rd_stb), .rd_addr_i(rd_addr),
    .irq_pin_o(irq_pin), .irq_od_o(irq_od), .rd_data_o(rd_data)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a; rd_stb = 1'b1; #1 d = rd_data;
    step(); rd_stb = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, int'(d), exp);
  endtask

  task automatic ev(input logic [4:0] nk, input logic ar, input logic d, input logic dr, input logic fo);
    nack = nk; arb = ar; dn = d; drdy = dr; fovf = fo;
    step();
    nack = '0; arb = 1'b0; dn = 1'b0; drdy = 1'b0; fovf = 1'b0;
  endtask

  task automatic clear_all();
    logic [7:0] d;
    rd(STA, d); rd(MST, d);
  endtask

  function automatic int act_lvl();
    return int'(irq_pin ^ pin_cfg[7]);
  endfunction

  task automatic pulse_len(output int n, input bit retrig);
    n = 0;
    while (act_lvl() == 1 && n < 100) begin
      n++;
      if (retrig && n == 3) ev(5'd0, 1'b0, 1'b0, 1'b1, 1'b0);
      else step();
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] d;
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk("R1 pin", int'(irq_pin), 0);
    rd_chk("R1 stat", STA, 0);
    rd_chk("R1 mst", MST, 0);

    // R2 R3 R6 per-bit sweep of master events
    for (int i = 0; i < 7; i++) begin
      ev(i < 5 ? 5'(1 << i) : 5'd0, i == 5, i == 6, 1'b0, 1'b0);
      step();
      rd_chk("R2 mst bit", MST, 1 << i);
      rd_chk("R3 mst cleared", MST, 0);
      rd_chk("R6 summary", STA, 8'h08);
    end

    // R6 gating
    s4en = 1'b0;
    ev(5'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    rd_chk("R6 s4 done recorded", MST, 8'h40);
    rd_chk("R6 s4 gated", STA, 0);
    s4en = 1'b1;
    irq_en = 8'h11;
    ev(5'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_chk("R6 mst en off", STA, 0);
    rd_chk("R6 nack recorded", MST, 8'h01);

    // R4 R5 enable sweep with reserved enables set
    for (int e = 0; e < 8; e++) begin
      irq_en = 8'hE6 | (e[0] ? 8'h01 : 8'h00) | (e[1] ? 8'h08 : 8'h00) | (e[2] ? 8'h10 : 8'h00);
      ev(5'd1, 1'b0, 1'b0, 1'b1, 1'b1);
      rd_chk("R4 stat layout", STA, (e[0] ? 1 : 0) | (e[1] ? 8 : 0) | (e[2] ? 16 : 0));
      rd_chk("R5 stat cleared", STA, 0);
      rd(MST, d);
    end
    irq_en = 8'h19;

    // R7 sync pass-through sweep
    for (int pol = 0; pol < 2; pol++) begin
      for (int en = 0; en < 2; en++) begin
        pin_cfg = 8'h20 | 8'(pol << 3);
        sync = pol[0];
        step(); step();
        pin_cfg = pin_cfg | 8'(en << 2);
        step();
        sync = ~pol[0];
        step(); step();
        rd_chk("R7 pass bit", MST, en ? 8'h80 : 8'h00);
        rd_chk("R7 summary", STA, en ? 8'h08 : 8'h00);
        sync = pol[0];
        step(); step();
        rd_chk("R7 release ignored", MST, 0);
      end
    end
    pin_cfg = 8'h20; sync = 1'b0;
    step(); step();

    // R13 R8 read address scope
    ev(5'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    rd_chk("R13 other addr data", 8'h05, 0);
    rd_chk("R13 no clear stat", STA, 8'h09);
    ev(5'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    pin_cfg = 8'h30;
    rd_chk("R8 any read data", 8'h05, 0);
    pin_cfg = 8'h20;
    rd_chk("R8 stat cleared", STA, 0);
    rd_chk("R8 mst cleared", MST, 0);

    // R9 event in the clearing cycle
    ev(5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    drdy = 1'b1;
    rd(STA, d);
    drdy = 1'b0;
    chk("R9 old contents", int'(d), 8'h10);
    rd_chk("R9 drdy kept", STA, 8'h01);
    nack = 5'd4;
    rd(MST, d);
    nack = '0;
    chk("R9 mst old", int'(d), 0);
    rd_chk("R9 nack kept", MST, 8'h04);
    clear_all();

    // R10 latched
    ev(5'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R10 pin set", int'(irq_pin), 1);
    step(); step(); step();
    chk("R10 pin holds", int'(irq_pin), 1);
    irq_en = 8'h18; #1;
    chk("R10 masked", int'(irq_pin), 0);
    irq_en = 8'h19; #1;
    chk("R10 unmasked", int'(irq_pin), 1);
    rd(STA, d);
    chk("R10 cleared", int'(irq_pin), 0);

    // R12 polarity and open drain
    pin_cfg = 8'hA0; #1;
    chk("R12 idle low-active", int'(irq_pin), 1);
    ev(5'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R12 asserted low", int'(irq_pin), 0);
    rd(STA, d);
    chk("R12 released", int'(irq_pin), 1);
    pin_cfg = 8'h60; #1;
    chk("R12 od on", int'(irq_od), 1);
    pin_cfg = 8'h20; #1;
    chk("R12 od off", int'(irq_od), 0);

    // R11 pulse mode
    pin_cfg = 8'h00;
    step();
    ev(5'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    pulse_len(n, 1'b0);
    chk("R11 pulse width", n, P);
    pin_cfg = 8'h80;
    ev(5'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_len(n, 1'b0);
    chk("R11 pulse width low", n, P);
    pin_cfg = 8'h00;
    ev(5'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    pulse_len(n, 1'b1);
    chk("R11 retrigger", n, P + 3);
    irq_en = 8'h18;
    ev(5'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    pulse_len(n, 1'b0);
    chk("R11 masked no pulse", n, 0);
    irq_en = 8'h19;
    clear_all();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule